// File: doc/BRIEF.md
# Bit-Level Streaming Serial Port

This block connects a 2.4 GHz low-rate radio running in streaming mode to an external DSP, one bit at a time. On receive, a start-of-frame strobe from the demodulator starts a fixed delay. After it, the block drives a gated bit clock in bursts of four bits, one burst per symbol. During each burst it shifts out the current demodulated 4-bit symbol on a receive data line, least significant bit first.

On transmit, a TX-enter command powers the PA. After a ramp delay the block drives the same burst-shaped bit clock and captures serial data from the DSP on the edge chosen by the edge-select input. Each group of four captured bits is presented as a symbol with a one-cycle valid strobe. A return-to-ready command stops the clock and drops PA power at once. Every delay is counted in system clock cycles, from a cycles-per-microsecond parameter.

Top module: `bsp_stream_port`

## Requirements
- R1: While reset is held low, and on the cycle after it is released, bclk, rx_dat, pa_on, tx_sym_vld and tx_sym are all 0.
- R2: When sfd_det is sampled high in the idle state, bclk first goes high START_US*CYC_PER_US cycles after the sampling edge.
- R3: In the running state each bit lasts BIT_US*CYC_PER_US cycles, with bclk high for the first half and low for the second half. Each burst holds SYM_BITS bits and bursts start every BURST_US*CYC_PER_US cycles. bclk stays low for the rest of each burst period.
- R4: In receive, rx_sym is sampled at the edge that starts each burst. During bit k of the burst (k = 0 first), rx_dat carries bit k of that sample. rx_dat changes only at bit starts, so it is stable for the whole high half before the falling edge. rx_dat is 0 outside bit slots.
- R5: tx_go sampled in idle sets pa_on on the next cycle. bclk first goes high RAMP_US*CYC_PER_US cycles after the sampling edge, so bclk never runs in transmit without pa_on.
- R6: With tx_fall = 0, tx_dat is captured in the first system cycle of each bclk high half. With tx_fall = 1, it is captured in the first system cycle of each low half.
- R7: In the cycle after the SYM_BITS-th capture of a burst, tx_sym_vld is high for one cycle and tx_sym holds the captures, with the first capture in bit 0. tx_sym keeps its value until the next symbol.
- R8: rdy_cmd sampled high in any state returns the block to idle. On the next cycle bclk and pa_on are 0, and a capture falling in the rdy_cmd cycle is discarded.
- R9: Outside idle, sfd_det and tx_go have no effect on bclk, rx_dat or pa_on.
- R10: In idle, the priority is rdy_cmd over tx_go over sfd_det.
- R11: In transmit, rx_dat stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfd_det | input | 1 | Start-of-frame detected strobe |
| rx_sym | input | 4 | Current demodulated symbol |
| tx_go | input | 1 | Enter-transmit command strobe |
| rdy_cmd | input | 1 | Return-to-ready command strobe |
| tx_fall | input | 1 | TX capture edge: 0 high half, 1 low half |
| tx_dat | input | 1 | Serial transmit data from the DSP |
| bclk | output | 1 | Gated bit clock |
| rx_dat | output | 1 | Serial receive data |
| tx_sym | output | 4 | Assembled transmit symbol |
| tx_sym_vld | output | 1 | One-cycle strobe for tx_sym |
| pa_on | output | 1 | PA power control |

## Verification
The bench builds the block with CYC_PER_US = 2 and RAMP_US = 3, keeping the other parameters at their defaults. This gives a 36-cycle receive start, a 6-cycle PA ramp, a 4-cycle bit with 2-cycle halves and a 32-cycle burst. Several whole bursts, mid-burst commands and both capture edges then fit in under a thousand cycles. The halves of two cycles let a capture on the wrong edge show up, because the bench changes tx_dat every cycle.

// File: rtl/bsp_pkg.sv
// Shared types for the bit-level streaming port.
package bsp_pkg;
    // Sequencer phase: idle, start/ramp delay, bursts running.
    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RUN} bsp_phase_t;
endpackage

// File: rtl/bsp_timer.sv
// Sequencer and bit-clock generator.
// Counts the start delay (receive) or PA ramp (transmit), then walks
// through bit slots of a burst. Assumes BIT_CYC is even, SYM_BITS is
// smaller than the slot count, and both delays are at least one cycle.
module bsp_timer
    import bsp_pkg::*;
#(
    parameter int CYC_PER_US = 26,
    parameter int START_US   = 18,
    parameter int RAMP_US    = 4,
    parameter int BIT_US     = 2,
    parameter int BURST_US   = 16,
    parameter int SYM_BITS   = 4,
    localparam int BIT_CYC   = BIT_US * CYC_PER_US,
    localparam int SLOTS     = BURST_US / BIT_US,
    localparam int SUBW      = $clog2(BIT_CYC),
    localparam int SLW       = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sfd_det,
    input  logic            tx_go,
    input  logic            rdy_cmd,
    output logic            run_o,
    output logic            tx_mode_o,
    output logic            pa_on_o,
    output logic            bclk_o,
    output logic            burst_ld_o,
    output logic [SLW-1:0]  slot_o,
    output logic [SUBW-1:0] sub_o
);
    localparam int START_CYC = START_US * CYC_PER_US;
    localparam int RAMP_CYC  = RAMP_US * CYC_PER_US;
    localparam int MAXW      = (START_CYC > RAMP_CYC) ? START_CYC : RAMP_CYC;
    localparam int CW        = $clog2(MAXW + 1);
    localparam logic [CW-1:0]   RX_LAST   = CW'(START_CYC - 1);
    localparam logic [CW-1:0]   TX_LAST   = CW'(RAMP_CYC - 1);
    localparam logic [SUBW-1:0] SUB_LAST  = SUBW'(BIT_CYC - 1);
    localparam logic [SUBW-1:0] SUB_HALF  = SUBW'(BIT_CYC / 2);
    localparam logic [SLW-1:0]  SLOT_LAST = SLW'(SLOTS - 1);
    localparam logic [SLW-1:0]  BIT_LAST  = SLW'(SYM_BITS - 1);

    bsp_phase_t      phase;
    logic [CW-1:0]   cnt;
    logic [SUBW-1:0] sub;
    logic [SLW-1:0]  slot;
    logic            tx_q;
    logic            pa_q;
    logic            wait_done;

    // Detect the last cycle of the current delay.
    always_comb wait_done = (cnt == (tx_q ? TX_LAST : RX_LAST));

    // Flag the edges that start a new burst.
    always_comb burst_ld_o = !rdy_cmd &&
        ((phase == PH_WAIT && wait_done) ||
         (phase == PH_RUN && sub == SUB_LAST && slot == SLOT_LAST));

    // Phase, delay counter, slot position, direction and PA state.
    always_ff @(posedge clk) begin
        if (!rst_n || rdy_cmd) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sub   <= '0;
            slot  <= '0;
            pa_q  <= 1'b0;
            if (!rst_n) tx_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (tx_go) begin
                        phase <= PH_WAIT;
                        tx_q  <= 1'b1;
                        pa_q  <= 1'b1;
                    end else if (sfd_det) begin
                        phase <= PH_WAIT;
                        tx_q  <= 1'b0;
                    end
                end
                PH_WAIT: begin
                    if (wait_done) begin
                        phase <= PH_RUN;
                        sub   <= '0;
                        slot  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (sub == SUB_LAST) begin
                        sub  <= '0;
                        slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Present the sequencer state and the gated bit clock.
    always_comb begin
        run_o     = (phase == PH_RUN);
        tx_mode_o = tx_q;
        pa_on_o   = pa_q;
        slot_o    = slot;
        sub_o     = sub;
        bclk_o    = run_o && (slot <= BIT_LAST) && (sub < SUB_HALF);
    end

    // R8
    rdy_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_cmd |=> (!bclk_o && !pa_on_o));
    // R5
    pa_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_o && tx_q) |-> pa_q);
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !rdy_cmd && (sfd_det || tx_go)) |=> ($stable(tx_q) && phase != PH_IDLE));
endmodule

// File: rtl/bsp_rx_ser.sv
// Receive serializer.
// Latches the demodulated symbol at each burst start and presents one
// bit per slot, least significant first. Assumes slot numbering from
// the sequencer, with SYM_BITS a power of two.
module bsp_rx_ser #(
    parameter int SYM_BITS = 4,
    parameter int SLW      = 3,
    localparam int IW      = $clog2(SYM_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                burst_ld,
    input  logic                run,
    input  logic                tx_mode,
    input  logic                bclk,
    input  logic [SLW-1:0]      slot,
    input  logic [SYM_BITS-1:0] rx_sym,
    output logic                rx_dat
);
    localparam logic [SLW-1:0] BIT_LAST = SLW'(SYM_BITS - 1);

    logic [SYM_BITS-1:0] sym_q;

    // Hold the symbol for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n)        sym_q <= '0;
        else if (burst_ld) sym_q <= rx_sym;
    end

    // Select the bit of the current slot.
    always_comb rx_dat = (run && !tx_mode && slot <= BIT_LAST) ? sym_q[slot[IW-1:0]] : 1'b0;

    // R4
    rxd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && $past(bclk)) |-> $stable(rx_dat));
    // R11
    rxd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode |-> !rx_dat);
endmodule

// File: rtl/bsp_tx_des.sv
// Transmit deserializer.
// Captures serial data once per bit on the selected half of the bit
// clock and emits each full symbol with a one-cycle strobe. Assumes
// the sequencer's slot and sub-bit counters.
module bsp_tx_des #(
    parameter int SYM_BITS = 4,
    parameter int SLW      = 3,
    parameter int SUBW     = 6,
    parameter int HALF_CYC = 26,
    localparam int IW      = $clog2(SYM_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tx_mode,
    input  logic                rdy_cmd,
    input  logic                tx_fall,
    input  logic                tx_dat,
    input  logic [SLW-1:0]      slot,
    input  logic [SUBW-1:0]     sub,
    output logic [SYM_BITS-1:0] tx_sym,
    output logic                tx_sym_vld
);
    localparam logic [SLW-1:0]  BIT_LAST = SLW'(SYM_BITS - 1);
    localparam logic [SUBW-1:0] SUB_HALF = SUBW'(HALF_CYC);

    logic [SYM_BITS-1:0] sh_q;
    logic [SYM_BITS-1:0] sh_n;
    logic                samp;

    // Decide whether this cycle is a capture cycle.
    always_comb begin
        samp = run && tx_mode && !rdy_cmd && (slot <= BIT_LAST) &&
               (sub == (tx_fall ? SUB_HALF : '0));
        sh_n = sh_q;
        sh_n[slot[IW-1:0]] = tx_dat;
    end

    // Shift in captures and publish the completed symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            tx_sym     <= '0;
            tx_sym_vld <= 1'b0;
        end else begin
            tx_sym_vld <= 1'b0;
            if (samp) begin
                sh_q <= sh_n;
                if (slot == BIT_LAST) begin
                    tx_sym     <= sh_n;
                    tx_sym_vld <= 1'b1;
                end
            end
        end
    end

    // R7
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sym_vld |=> !tx_sym_vld);
endmodule

// File: rtl/bsp_stream_port.sv
// Bit-level streaming serial port, top level.
// Ties the sequencer to the receive serializer and the transmit
// deserializer. All delays are counted in system clock cycles from
// CYC_PER_US. Commands are expected as single-cycle strobes.
module bsp_stream_port #(
    parameter int CYC_PER_US = 26,
    parameter int START_US   = 18,
    parameter int RAMP_US    = 4,
    parameter int BIT_US     = 2,
    parameter int BURST_US   = 16,
    parameter int SYM_BITS   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sfd_det,
    input  logic [SYM_BITS-1:0] rx_sym,
    input  logic                tx_go,
    input  logic                rdy_cmd,
    input  logic                tx_fall,
    input  logic                tx_dat,
    output logic                bclk,
    output logic                rx_dat,
    output logic [SYM_BITS-1:0] tx_sym,
    output logic                tx_sym_vld,
    output logic                pa_on
);
    localparam int BIT_CYC = BIT_US * CYC_PER_US;
    localparam int SLOTS   = BURST_US / BIT_US;
    localparam int SUBW    = $clog2(BIT_CYC);
    localparam int SLW     = $clog2(SLOTS);

    logic            run;
    logic            tx_mode;
    logic            burst_ld;
    logic [SLW-1:0]  slot;
    logic [SUBW-1:0] sub;

    bsp_timer #(
        .CYC_PER_US(CYC_PER_US), .START_US(START_US), .RAMP_US(RAMP_US),
        .BIT_US(BIT_US), .BURST_US(BURST_US), .SYM_BITS(SYM_BITS)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .sfd_det(sfd_det), .tx_go(tx_go),
        .rdy_cmd(rdy_cmd), .run_o(run), .tx_mode_o(tx_mode), .pa_on_o(pa_on),
        .bclk_o(bclk), .burst_ld_o(burst_ld), .slot_o(slot), .sub_o(sub)
    );

    bsp_rx_ser #(.SYM_BITS(SYM_BITS), .SLW(SLW)) u_rx (
        .clk(clk), .rst_n(rst_n), .burst_ld(burst_ld), .run(run),
        .tx_mode(tx_mode), .bclk(bclk), .slot(slot), .rx_sym(rx_sym),
        .rx_dat(rx_dat)
    );

    bsp_tx_des #(
        .SYM_BITS(SYM_BITS), .SLW(SLW), .SUBW(SUBW), .HALF_CYC(BIT_CYC / 2)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .run(run), .tx_mode(tx_mode),
        .rdy_cmd(rdy_cmd), .tx_fall(tx_fall), .tx_dat(tx_dat), .slot(slot),
        .sub(sub), .tx_sym(tx_sym), .tx_sym_vld(tx_sym_vld)
    );
endmodule

// File: tb/sim_bsp_stream_port.sv
// Bench: behavioural per-cycle model compared on every falling clock edge.
module sim_bsp_stream_port;
    localparam int CPU   = 2;
    localparam int START = 18 * CPU;
    localparam int RAMP  = 3 * CPU;
    localparam int TBIT  = 2 * CPU;
    localparam int HALF  = TBIT / 2;
    localparam int TBUR  = 16 * CPU;
    localparam int NB    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfd_det = 1'b0;
    logic [3:0] rx_sym = 4'h0;
    logic       tx_go = 1'b0;
    logic       rdy_cmd = 1'b0;
    logic       tx_fall = 1'b0;
    logic       tx_dat = 1'b0;
    logic       bclk, rx_dat, tx_sym_vld, pa_on;
    logic [3:0] tx_sym;

    bsp_stream_port #(.CYC_PER_US(CPU), .RAMP_US(3)) u0 (
        .clk(clk), .rst_n(rst_n), .sfd_det(sfd_det), .rx_sym(rx_sym),
        .tx_go(tx_go), .rdy_cmd(rdy_cmd), .tx_fall(tx_fall), .tx_dat(tx_dat),
        .bclk(bclk), .rx_dat(rx_dat), .tx_sym(tx_sym),
        .tx_sym_vld(tx_sym_vld), .pa_on(pa_on)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string tag = "R1";

    // Model state: mode 0 idle, 1 delay, 2 running.
    int m_mode = 0, m_tx = 0, m_cnt = 0, m_t = 0, m_pa = 0;
    int m_sym = 0, m_sh = 0, m_txsym = 0, m_vld = 0;

    always @(posedge clk) begin
        int p, b, nv;
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
        if (!rst_n) begin
            m_mode = 0; m_tx = 0; m_cnt = 0; m_t = 0; m_pa = 0;
            m_sym = 0; m_sh = 0; m_txsym = 0; m_vld = 0;
        end else begin
            nv = 0;
            if (m_mode == 2 && m_tx == 1 && !rdy_cmd) begin
                p = m_t % TBUR;
                if (p < NB * TBIT && (p % TBIT) == (tx_fall ? HALF : 0)) begin
                    b = p / TBIT;
                    m_sh = (m_sh & ~(1 << b)) | (int'(tx_dat) << b);
                    if (b == NB - 1) begin
                        m_txsym = m_sh;
                        nv = 1;
                    end
                end
            end
            if (rdy_cmd) begin
                m_mode = 0; m_pa = 0;
            end else if (m_mode == 0) begin
                if (tx_go) begin
                    m_mode = 1; m_tx = 1; m_cnt = 0; m_pa = 1;
                end else if (sfd_det) begin
                    m_mode = 1; m_tx = 0; m_cnt = 0;
                end
            end else if (m_mode == 1) begin
                if (m_cnt == (m_tx ? RAMP : START) - 1) begin
                    m_mode = 2; m_t = 0;
                    if (!m_tx) m_sym = int'(rx_sym);
                end else m_cnt++;
            end else begin
                m_t++;
                if ((m_t % TBUR) == 0 && !m_tx) m_sym = int'(rx_sym);
            end
            m_vld = nv;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s (%s) actual=%0d expected=%0d at cycle %0d", req, what, tag, act, exp, cyc);
        end
    endtask

    // One cycle: compare at the falling edge, then drive fresh random data.
    task automatic tick();
        int p, eb, er;
        @(negedge clk);
        p = m_t % TBUR;
        eb = (m_mode == 2 && p < NB * TBIT && (p % TBIT) < HALF) ? 1 : 0;
        er = (m_mode == 2 && !m_tx && p < NB * TBIT) ? ((m_sym >> (p / TBIT)) & 1) : 0;
        chk("R3", "bclk", int'(bclk), eb);
        chk(m_tx ? "R11" : "R4", "rx_dat", int'(rx_dat), er);
        chk("R5", "pa_on", int'(pa_on), m_pa);
        chk("R7", "tx_sym_vld", int'(tx_sym_vld), m_vld);
        chk("R7", "tx_sym", int'(tx_sym), m_txsym);
        rx_sym = 4'($urandom);
        tx_dat = 1'($urandom);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Cycles from a command strobe until bclk is first observed high.
    task automatic latency(input string req, input int exp);
        int j;
        j = 1;
        tick();
        sfd_det = 1'b0;
        tx_go = 1'b0;
        while (!bclk && j < 200) begin
            tick();
            j++;
        end
        chk(req, "first bclk latency", j, exp);
    endtask

    task automatic ready();
        rdy_cmd = 1'b1;
        tick();
        rdy_cmd = 1'b0;
        tick();
        chk("R8", "bclk after ready", int'(bclk), 0);
        chk("R8", "pa_on after ready", int'(pa_on), 0);
    endtask

    initial begin
        // R1 reset state
        run(4);
        rst_n = 1'b1;
        tick();
        chk("R1", "bclk", int'(bclk), 0);
        chk("R1", "rx_dat", int'(rx_dat), 0);
        chk("R1", "pa_on", int'(pa_on), 0);
        chk("R1", "tx_sym_vld", int'(tx_sym_vld), 0);
        chk("R1", "tx_sym", int'(tx_sym), 0);
        run(3);

        // R2 receive start delay, then R3/R4 bursts
        tag = "R2";
        sfd_det = 1'b1;
        latency("R2", START + 1);
        tag = "R4";
        run(130);
        // R9 commands while busy are ignored
        tag = "R9";
        tx_go = 1'b1; tick(); tx_go = 1'b0;
        run(5);
        sfd_det = 1'b1; tick(); sfd_det = 1'b0;
        chk("R9", "pa_on while receiving", int'(pa_on), 0);
        run(40);
        tag = "R8";
        ready();
        run(20);

        // R5 transmit ramp, R6 capture on the high half
        tag = "R5";
        tx_fall = 1'b0;
        tx_go = 1'b1;
        latency("R5", RAMP + 1);
        tag = "R6";
        run(110);
        tag = "R8";
        ready();
        run(6);

        // R6 capture on the low half, ready mid-burst
        tx_fall = 1'b1;
        run(2);
        tag = "R6";
        tx_go = 1'b1;
        latency("R5", RAMP + 1);
        run(101);
        tag = "R8";
        ready();
        run(20);

        // R10 priorities in idle
        tag = "R10";
        tx_go = 1'b1; sfd_det = 1'b1; tick(); tx_go = 1'b0; sfd_det = 1'b0;
        run(20);
        chk("R10", "tx_go wins over sfd_det", int'(pa_on), 1);
        ready();
        run(4);
        rdy_cmd = 1'b1; tx_go = 1'b1; tick(); rdy_cmd = 1'b0; tx_go = 1'b0;
        run(10);
        chk("R10", "rdy_cmd wins over tx_go", int'(pa_on), 0);

        // R8 ready during the start delay
        tag = "R8";
        sfd_det = 1'b1; tick(); sfd_det = 1'b0;
        run(10);
        ready();
        run(60);
        chk("R8", "no clock after aborted delay", int'(bclk), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule